// File: doc/BRIEF.md
# Design-Multiplexer Control Register Slave

This block sits on a Wishbone bus driven by a management controller and holds the control state that a pad multiplexer needs to pick one of several on-die user designs. It has three stores. The first is a selection register with a 4-bit design index and two override bits. The override bits let software force the active design into reset. The second is a 32-bit settings word that is broadcast to every design. The third is a free-running counter for debugging. A fourth address window is not stored here. It is decoded and passed through to an external byte-wide RAM, and the RAM's read data is returned on the bus.

The block accepts one access per request. It raises the acknowledge in the cycle that follows the request, and a write takes effect at that same edge. The select index, the two override bits and the settings word leave the block as plain outputs for the multiplexer and the designs. The pad routing and the RAM storage sit outside this block.

Top module: `prjsel_csr`

## Requirements
- R1: After reset, and again whenever reset is asserted, `proj_sel_o`, `ovr_en_o`, `ovr_rst_o`, `settings_o` and `wb_ack_o` are all 0.
- R2: A request (`wb_cyc_i` and `wb_stb_i` both high) accepted at one clock edge raises `wb_ack_o` for exactly one cycle after that edge. If a request is held high continuously, the acknowledge alternates 1,0,1,0.
- R3: A write to address 0x30800000 loads data bit 0 into `ovr_en_o`, bit 1 into `ovr_rst_o` and bits 5:2 into `proj_sel_o`. The new values are visible in the acknowledge cycle, and a read returns them in the same bit positions.
- R4: Bits 31:6 of the selection register read as 0, whatever value was written to them.
- R5: Address 0x30200000 holds a 32-bit settings word. A write loads all 32 bits, a read returns them, and `settings_o` shows the stored value.
- R6: The counter at 0x30400000 increases by one every clock. Two reads whose accepting edges are N cycles apart return values that differ by N.
- R7: A write to the counter address is acknowledged. It does not change the counting sequence, and it does not change the selection or settings registers.
- R8: When an accepted access has address bits 31:8 equal to 0x301000, `ram_cs_o` is driven high in the request cycle. In the same cycle, `ram_addr_o` carries address bits 7:2, `ram_we_o` carries the write flag and `ram_wdata_o` carries data bits 7:0. On a read, `wb_dat_o` returns `ram_rdata_i` zero-extended in the acknowledge cycle. The RAM presents that data one cycle after its select.
- R9: An access to any other address is acknowledged. It reads as 0 and changes no stored state.
- R10: While `wb_cyc_i` or `wb_stb_i` is low, no acknowledge follows, no register changes and `ram_cs_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid while `wb_ack_o` is high |
| wb_ack_o | output | 1 | Acknowledge |
| ram_cs_o | output | 1 | RAM window select in the request cycle |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 6 | RAM word index |
| ram_wdata_o | output | 8 | RAM write byte |
| ram_rdata_i | input | 8 | RAM read byte, one cycle after select |
| proj_sel_o | output | 4 | Active design index |
| ovr_en_o | output | 1 | Override enable |
| ovr_rst_o | output | 1 | Forced reset of the active design |
| settings_o | output | 32 | Settings word broadcast to all designs |

## Verification
The assertions assume three things about the environment. First, the master keeps address, write flag and data stable while its request is pending. Second, the attached RAM returns its byte exactly one cycle after `ram_cs_o`. Third, reset is the only way stored values return to zero.

The bench drives all inputs on falling edges and samples on the next falling edge. It drops the strobe in the acknowledge cycle for ordinary accesses. One directed test holds the request on deliberately, to show that the acknowledge alternates rather than repeating. The RAM is modelled inside the bench with exactly one cycle of read latency.

// File: rtl/csr_pkg.sv
package csr_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SEL,
        TGT_CNT,
        TGT_SET,
        TGT_RAM
    } tgt_e;

    // bit positions inside the selection register; the multiplexer decodes these
    localparam int OE_BIT  = 0;
    localparam int RST_BIT = 1;
    localparam int SEL_LSB = 2;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                RAM_AW   = 6,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 'h3080_0000,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 'h3040_0000,
    parameter logic [ADDR_W-1:0] SET_ADDR = 'h3020_0000,
    parameter logic [ADDR_W-1:0] RAM_BASE = 'h3010_0000
) (
    input  logic [ADDR_W-1:0] adr,
    output tgt_e              tgt
);
    localparam int RAM_SHIFT = RAM_AW + 2;

    logic ram_hit;

    always_comb begin
        ram_hit = ((adr >> RAM_SHIFT) == (RAM_BASE >> RAM_SHIFT));
        if (adr == SEL_ADDR)      tgt = TGT_SEL;
        else if (adr == CNT_ADDR) tgt = TGT_CNT;
        else if (adr == SET_ADDR) tgt = TGT_SET;
        else if (ram_hit)         tgt = TGT_RAM;
        else                      tgt = TGT_NONE;
    end

endmodule

// File: rtl/csr_free_counter.sv
module csr_free_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/csr_rdata_mux.sv
module csr_rdata_mux
    import csr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4,
    parameter int CNT_W  = 32
) (
    input  tgt_e              tgt,
    input  logic              oe,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] settings,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] cnt_word;

    always_comb begin
        sel_word                   = '0;
        sel_word[OE_BIT]           = oe;
        sel_word[RST_BIT]          = rst;
        sel_word[SEL_LSB +: SEL_W] = sel;
        cnt_word                   = '0;
        cnt_word[CNT_W-1:0]        = count;
        unique case (tgt)
            TGT_SEL: rdata = sel_word;
            TGT_CNT: rdata = cnt_word;
            TGT_SET: rdata = settings;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/prjsel_csr.sv
module prjsel_csr
    import csr_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter int                SEL_W    = 4,
    parameter int                CNT_W    = 32,
    parameter int                RAM_AW   = 6,
    parameter int                RAM_DW   = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 'h3080_0000,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 'h3040_0000,
    parameter logic [ADDR_W-1:0] SET_ADDR = 'h3020_0000,
    parameter logic [ADDR_W-1:0] RAM_BASE = 'h3010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADDR_W-1:0] wb_adr_i,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic              wb_ack_o,
    output logic              ram_cs_o,
    output logic              ram_we_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic [RAM_DW-1:0] ram_wdata_o,
    input  logic [RAM_DW-1:0] ram_rdata_i,
    output logic [SEL_W-1:0]  proj_sel_o,
    output logic              ovr_en_o,
    output logic              ovr_rst_o,
    output logic [DATA_W-1:0] settings_o
);
    localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

    typedef struct packed {
        logic              ack;
        logic              rd_ram;
        logic [DATA_W-1:0] rdata;
        logic              oe;
        logic              rst;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] settings;
    } state_t;

    state_t            st_d, st_q;
    logic              req, acc;
    tgt_e              tgt;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] ram_word;

    csr_addr_decode #(
        .ADDR_W  (ADDR_W),
        .RAM_AW  (RAM_AW),
        .SEL_ADDR(SEL_ADDR),
        .CNT_ADDR(CNT_ADDR),
        .SET_ADDR(SET_ADDR),
        .RAM_BASE(RAM_BASE)
    ) u_dec (
        .adr(wb_adr_i),
        .tgt(tgt)
    );

    csr_free_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .count(count)
    );

    csr_rdata_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_mux (
        .tgt     (tgt),
        .oe      (st_q.oe),
        .rst     (st_q.rst),
        .sel     (st_q.sel),
        .settings(st_q.settings),
        .count   (count),
        .rdata   (reg_rdata)
    );

    always_comb begin
        req         = wb_cyc_i & wb_stb_i;
        acc         = req & ~st_q.ack;
        st_d        = st_q;
        st_d.ack    = acc;
        st_d.rd_ram = acc & ~wb_we_i & (tgt == TGT_RAM);
        st_d.rdata  = (acc & ~wb_we_i) ? reg_rdata : '0;
        if (acc && wb_we_i) begin
            unique case (tgt)
                TGT_SEL: begin
                    st_d.oe  = wb_dat_i[OE_BIT];
                    st_d.rst = wb_dat_i[RST_BIT];
                    st_d.sel = wb_dat_i[SEL_MSB:SEL_LSB];
                end
                TGT_SET: st_d.settings = wb_dat_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ram_word              = '0;
        ram_word[RAM_DW-1:0]  = ram_rdata_i;
    end

    assign wb_ack_o    = st_q.ack;
    assign wb_dat_o    = st_q.rd_ram ? ram_word : st_q.rdata;
    assign ram_cs_o    = acc & (tgt == TGT_RAM);
    assign ram_we_o    = wb_we_i;
    assign ram_addr_o  = wb_adr_i[RAM_AW+1:2];
    assign ram_wdata_o = wb_dat_i[RAM_DW-1:0];
    assign proj_sel_o  = st_q.sel;
    assign ovr_en_o    = st_q.oe;
    assign ovr_rst_o   = st_q.rst;
    assign settings_o  = st_q.settings;

    // R2
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wb_ack_o) |=> wb_ack_o);

    // R10
    no_req_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !wb_ack_o);

    // R10
    ram_cs_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs_o |-> (wb_cyc_i && wb_stb_i));

    // R3
    sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wb_we_i && tgt == TGT_SEL) |=>
            (proj_sel_o == $past(wb_dat_i[SEL_MSB:SEL_LSB]) && ovr_rst_o == $past(wb_dat_i[RST_BIT])));

    // R5
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && wb_we_i && tgt == TGT_SET) |=> $stable(settings_o));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !wb_we_i && tgt == TGT_NONE) |=> wb_dat_o == '0);

endmodule

// File: tb/prjsel_csr_bench.sv
module prjsel_csr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [31:0] A_SEL = 32'h3080_0000;
    localparam logic [31:0] A_CNT = 32'h3040_0000;
    localparam logic [31:0] A_SET = 32'h3020_0000;
    localparam logic [31:0] A_RAM = 32'h3010_0000;
    localparam logic [31:0] A_BAD = 32'h3000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [31:0] adr = '0, wdat = '0;
    logic [31:0] rdat;
    logic        ack, ram_cs, ram_we;
    logic [5:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [3:0]  psel;
    logic        oe, orst;
    logic [31:0] settings;

    int checks = 0, fails = 0, cycles = 0;
    logic [7:0] mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    prjsel_csr u_prjsel_csr (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
        .ram_cs_o(ram_cs), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
        .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
        .proj_sel_o(psel), .ovr_en_o(oe), .ovr_rst_o(orst), .settings_o(settings)
    );

    // RAM model: one-cycle read latency
    always @(posedge clk) begin
        if (ram_cs) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_rdata <= mem[ram_addr];
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    // drive on negedge, sample in ack cycle, then one idle cycle
    task automatic bus(input logic w, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic got_ack);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
        @(posedge clk);
        @(negedge clk);
        got_ack = ack;
        rd = rdat;
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);
    endtask

    typedef struct packed {
        logic        w;
        logic        chk;
        logic [31:0] a;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{1'b1, 1'b0, A_SEL, 32'hFFFF_FFFF, 32'h0},          // R4 write all ones
        '{1'b0, 1'b1, A_SEL, 32'h0,         32'h0000_003F},  // R4 reserved read 0
        '{1'b1, 1'b0, A_SEL, 32'h0000_0016, 32'h0},          // R3 sel=5 rst=1 oe=0
        '{1'b0, 1'b1, A_SEL, 32'h0,         32'h0000_0016},  // R3 readback
        '{1'b1, 1'b0, A_SET, 32'hA5C3_0F96, 32'h0},          // R5
        '{1'b0, 1'b1, A_SET, 32'h0,         32'hA5C3_0F96},  // R5 readback
        '{1'b1, 1'b0, A_BAD, 32'h0000_DEAD, 32'h0},          // R9 write ignored
        '{1'b0, 1'b1, A_BAD, 32'h0,         32'h0},          // R9 reads 0
        '{1'b0, 1'b1, A_SET, 32'h0,         32'hA5C3_0F96},  // R9 no state change
        '{1'b1, 1'b0, A_RAM + 32'h4,  32'h1234_5677, 32'h0}, // R8 write word 1
        '{1'b1, 1'b0, A_RAM + 32'hFC, 32'h0000_00AB, 32'h0}, // R8 write last word
        '{1'b0, 1'b1, A_RAM + 32'h4,  32'h0, 32'h0000_0077}, // R8 byte read
        '{1'b0, 1'b1, A_RAM + 32'hFC, 32'h0, 32'h0000_00AB}, // R8 window end
        '{1'b1, 1'b0, A_CNT, 32'h0,         32'h0},          // R7 counter write
        '{1'b0, 1'b1, A_SEL, 32'h0,         32'h0000_0016}   // R7 sel unchanged
    };

    initial begin
        logic [31:0] rd, c1, c2;
        logic        a;

        repeat (3) @(negedge clk);
        // R1 state during reset
        check("R1 ack", {31'b0, ack}, 32'h0);
        check("R1 outputs", {psel, oe, orst, 26'b0}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 settings", settings, 32'h0);
        bus(1'b0, A_SEL, 32'h0, rd, a);
        check("R1 sel read", rd, 32'h0);

        foreach (VECS[i]) begin
            bus(VECS[i].w, VECS[i].a, VECS[i].d, rd, a);
            check("R2 ack per access", {31'b0, a}, 32'h1);
            if (VECS[i].chk) check($sformatf("vector %0d", i), rd, VECS[i].exp);
        end

        // R3 plain outputs
        check("R3 proj_sel_o", {28'b0, psel}, 32'h5);
        check("R3 ovr_rst_o", {31'b0, orst}, 32'h1);
        check("R3 ovr_en_o", {31'b0, oe}, 32'h0);
        check("R5 settings_o", settings, 32'hA5C3_0F96);
        bus(1'b1, A_SEL, 32'h0000_0021, rd, a);
        check("R3 oe and sel=8", {26'b0, psel, orst, oe}, 32'h0000_0021);

        // R6 counter rate
        bus(1'b0, A_CNT, 32'h0, c1, a);
        repeat (10) @(negedge clk);
        bus(1'b0, A_CNT, 32'h0, c2, a);
        check("R6 counter delta", c2 - c1, 32'd12);

        // R7 counter write has no effect on counting
        bus(1'b0, A_CNT, 32'h0, c1, a);
        bus(1'b1, A_CNT, 32'h0, rd, a);
        check("R7 write acked", {31'b0, a}, 32'h1);
        bus(1'b0, A_CNT, 32'h0, c2, a);
        check("R7 counter delta", c2 - c1, 32'd4);

        // R10 strobe without cycle, or cycle without strobe
        cyc = 1'b0; stb = 1'b1; we = 1'b1; adr = A_SET; wdat = 32'h1111_1111;
        repeat (3) begin
            @(negedge clk);
            check("R10 no ack", {30'b0, ack, ram_cs}, 32'h0);
        end
        cyc = 1'b1; stb = 1'b0; adr = A_RAM;
        @(negedge clk);
        check("R10 no ram_cs", {30'b0, ack, ram_cs}, 32'h0);
        cyc = 1'b0; we = 1'b0;
        check("R10 settings kept", settings, 32'hA5C3_0F96);

        // R2 held request acknowledges on alternate cycles
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = A_SEL;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R2 held pattern", {31'b0, ack}, (k % 2 == 0) ? 32'h1 : 32'h0);
        end
        cyc = 1'b0; stb = 1'b0;
        @(negedge clk);

        // R8 RAM strobe fields in request cycle
        cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = A_RAM + 32'h28; wdat = 32'h0000_005A;
        #1;
        check("R8 ram fields", {16'b0, ram_cs, ram_we, ram_addr, ram_wdata}, {16'b0, 1'b1, 1'b1, 6'd10, 8'h5A});
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);

        // R1 reset again clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", {psel, oe, orst, ack, 25'b0}, 32'h0);
        check("R1 re-reset settings", settings, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule